// File: doc/BRIEF.md
# Sub-Audio Tone Generator

This block synthesizes a continuous sub-audio squelch tone as a stream of signed digital samples. A 6-bit tone code picks one of 39 standard squelch-tone frequencies between 67.0 Hz and 250.3 Hz. Each code maps to a phase step that a 24-bit phase accumulator adds on every cycle of the reference clock, which runs at 1 MHz by default. The upper phase bits address a quarter-wave sine table. The sample port is updated and strobed once every `SAMPLE_DIV` clocks, so a downstream converter sees a steady sample rate.

Two indicators tell the output stage how to behave. One marks that a tone is being driven. The other marks that the line should sit at its idle bias level, which happens when the no-tone code is selected during transmit. In receive mode both indicators are low and the output stage stays open. In transmit, toggling the phase-reverse request moves the tone by half a cycle. Radios use this at the end of a transmission to cut off the squelch tail at the receiver. The accumulator takes the half-cycle jump in the same addition as its normal step, so no extra sample appears.

Top module: `subtone_gen`

## Requirements
- R1: Codes 0 to 38 select, in this order, 67.0, 69.3, 71.9, 74.4, 77.0, 79.7, 82.5, 85.4, 88.5, 91.5, 94.8, 97.4, 100.0, 103.5, 107.2, 110.9, 114.8, 118.8, 123.0, 127.3, 131.8, 136.5, 141.3, 146.2, 151.4, 156.7, 162.2, 167.9, 173.8, 179.9, 186.2, 192.8, 203.5, 210.7, 218.1, 225.7, 233.6, 241.8 and 250.3 Hz. With a `CLK_HZ` reference, the period of the sample sequence is within 0.3 % of the nominal period.
- R2: Codes 39 to 63 mean "no tone". When such a code is held with `tx_mode` = 1, then from the third clock edge on `drive_bias_o` = 1, `drive_tone_o` = 0, `sample_o` = 0, and no strobe occurs.
- R3: With `tx_mode` = 0, from the third clock edge on both indicators are 0, `sample_o` = 0 and no strobe occurs, whatever `flip_req` does.
- R4: While `drive_tone_o` = 1, `sample_vld_o` pulses for one cycle every `SAMPLE_DIV` cycles. It never pulses while `drive_tone_o` = 0.
- R5: `sample_o` is two's complement, `SAMP_W` bits wide, with magnitude at most 2^(SAMP_W-1)-1 (127 by default). Over a tone cycle its peak magnitude reaches at least 126.
- R6: In transmit, every change of `flip_req` shifts the tone phase by half a cycle, so the next samples are the negation of the waveform. A steady `flip_req` leaves the waveform continuous.
- R7: The phase starts at zero each time a tone begins. The first strobed sample lies in 0..8, and the second is not smaller than the first.
- R8: After reset every output is 0.
- R9: `drive_tone_o` and `drive_bias_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| tone_code | input | CODE_W (6) | Tone select; 39 to 63 = no tone |
| flip_req | input | 1 | Phase-reverse request, used in transmit only |
| sample_o | output | SAMP_W (8) | Signed sine sample |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |
| drive_tone_o | output | 1 | Tone output should be driven |
| drive_bias_o | output | 1 | Tone output should hold its bias level |

## Verification
The checker assumes that `tx_mode` and `tone_code` stay put for at least three cycles before it relates them to the indicators. It also assumes that `SAMPLE_DIV` is at least 2, so strobes never touch. The directed tasks change the mode, the code or the reverse request only at falling edges, and then settle for several cycles before sampling. Phase-reversal checks allow a few LSB of tolerance, because the accumulator keeps moving during the short wait between the samples being compared.

// File: rtl/subtone_pkg.sv
package subtone_pkg;

  localparam int NUM_TONES = 39;

  // Nominal tone frequency in tenths of a hertz, ascending by code.
  function automatic int tone_dhz(input int idx);
    case (idx)
      0: return 670;    1: return 693;    2: return 719;    3: return 744;
      4: return 770;    5: return 797;    6: return 825;    7: return 854;
      8: return 885;    9: return 915;    10: return 948;   11: return 974;
      12: return 1000;  13: return 1035;  14: return 1072;  15: return 1109;
      16: return 1148;  17: return 1188;  18: return 1230;  19: return 1273;
      20: return 1318;  21: return 1365;  22: return 1413;  23: return 1462;
      24: return 1514;  25: return 1567;  26: return 1622;  27: return 1679;
      28: return 1738;  29: return 1799;  30: return 1862;  31: return 1928;
      32: return 2035;  33: return 2107;  34: return 2181;  35: return 2257;
      36: return 2336;  37: return 2418;  38: return 2503;
      default: return 0;
    endcase
  endfunction

  // Rounded phase step: f * 2^acc_w / clk_hz, with f given in 0.1 Hz.
  function automatic longint step_for(input int dhz, input int acc_w, input longint clk_hz);
    longint num;
    longint den;
    num = longint'(dhz) <<< acc_w;
    den = 64'd10 * clk_hz;
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/subtone_step_rom.sv
module subtone_step_rom #(
  parameter int     CODE_W = 6,
  parameter int     ACC_W  = 24,
  parameter longint CLK_HZ = 1_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic [ACC_W-1:0]  step_o
);
  import subtone_pkg::*;

  localparam int DEPTH = 1 << CODE_W;

  logic [ACC_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      if (i < NUM_TONES) rom[i] = ACC_W'(step_for(tone_dhz(i), ACC_W, CLK_HZ));
      else               rom[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_o <= '0;
    else     step_o <= rom[code];
  end
endmodule

// File: rtl/subtone_phase_acc.sv
module subtone_phase_acc #(
  parameter int ACC_W = 24,
  parameter int TOP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rev,
  input  logic [ACC_W-1:0] step,
  output logic [TOP_W-1:0] phase_top_o
);
  logic [ACC_W-1:0] phase_q;
  logic             rev_q;
  logic [ACC_W-1:0] half;
  logic [ACC_W-1:0] jump;

  assign half = {1'b1, {(ACC_W-1){1'b0}}};
  assign jump = (rev != rev_q) ? half : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      rev_q   <= 1'b0;
    end else if (!run) begin
      phase_q <= '0;
      rev_q   <= rev;
    end else begin
      phase_q <= phase_q + step + jump;
      rev_q   <= rev;
    end
  end

  assign phase_top_o = phase_q[ACC_W-1 -: TOP_W];
endmodule

// File: rtl/subtone_sine_lut.sv
module subtone_sine_lut #(
  parameter int LUT_AW = 6,
  parameter int SAMP_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LUT_AW+1:0]        phase_top,
  output logic signed [SAMP_W-1:0] samp_o
);
  localparam int  MAG_W = SAMP_W - 1;
  localparam int  QTR   = 1 << LUT_AW;
  localparam int  AMP   = (1 << MAG_W) - 1;
  localparam real PI    = 3.14159265358979;

  logic [MAG_W-1:0]  mag_rom [QTR];
  logic [1:0]        quad;
  logic [LUT_AW-1:0] idx;
  logic [MAG_W-1:0]  mag;

  initial begin
    for (int i = 0; i < QTR; i++) begin
      real ang;
      ang = (real'(i) + 0.5) * PI / (2.0 * real'(QTR));
      mag_rom[i] = MAG_W'($rtoi(real'(AMP) * $sin(ang) + 0.5));
    end
  end

  assign quad = phase_top[LUT_AW+1 -: 2];
  assign idx  = quad[0] ? ~phase_top[LUT_AW-1:0] : phase_top[LUT_AW-1:0];
  assign mag  = mag_rom[idx];

  always_ff @(posedge clk) begin
    if (rst)          samp_o <= '0;
    else if (quad[1]) samp_o <= -$signed({1'b0, mag});
    else              samp_o <= $signed({1'b0, mag});
  end
endmodule

// File: rtl/subtone_gen.sv
module subtone_gen #(
  parameter longint CLK_HZ     = 1_000_000,
  parameter int     CODE_W     = 6,
  parameter int     ACC_W      = 24,
  parameter int     LUT_AW     = 6,
  parameter int     SAMP_W     = 8,
  parameter int     SAMPLE_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_mode,
  input  logic [CODE_W-1:0]        tone_code,
  input  logic                     flip_req,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic                     sample_vld_o,
  output logic                     drive_tone_o,
  output logic                     drive_bias_o
);
  import subtone_pkg::*;

  localparam int TOP_W = LUT_AW + 2;
  localparam int DIV_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;

  logic                     code_ok;
  logic                     run_q, bias_q, run_p1, bias_p1;
  logic [ACC_W-1:0]         step_q;
  logic [TOP_W-1:0]         phase_top;
  logic signed [SAMP_W-1:0] lut_samp;
  logic [DIV_W-1:0]         div_cnt;
  logic                     strobe;

  assign code_ok = (32'(tone_code) < 32'(NUM_TONES));

  // Mode decode, aligned with the registered step lookup.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      bias_q  <= 1'b0;
      run_p1  <= 1'b0;
      bias_p1 <= 1'b0;
    end else begin
      run_q   <= tx_mode & code_ok;
      bias_q  <= tx_mode & ~code_ok;
      run_p1  <= run_q;
      bias_p1 <= bias_q;
    end
  end

  subtone_step_rom #(.CODE_W(CODE_W), .ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_rom (
    .clk(clk), .rst(rst), .code(tone_code), .step_o(step_q)
  );

  subtone_phase_acc #(.ACC_W(ACC_W), .TOP_W(TOP_W)) u_acc (
    .clk(clk), .rst(rst), .run(run_q), .rev(tx_mode & flip_req),
    .step(step_q), .phase_top_o(phase_top)
  );

  subtone_sine_lut #(.LUT_AW(LUT_AW), .SAMP_W(SAMP_W)) u_lut (
    .clk(clk), .rst(rst), .phase_top(phase_top), .samp_o(lut_samp)
  );

  assign strobe = (div_cnt == DIV_W'(SAMPLE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)         div_cnt <= '0;
    else if (strobe) div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o     <= '0;
      sample_vld_o <= 1'b0;
      drive_tone_o <= 1'b0;
      drive_bias_o <= 1'b0;
    end else begin
      drive_tone_o <= run_p1;
      drive_bias_o <= bias_p1;
      sample_vld_o <= strobe & run_p1;
      if (!run_p1)     sample_o <= '0;
      else if (strobe) sample_o <= lut_samp;
    end
  end
endmodule

// File: rtl/subtone_gen_chk.sv
module subtone_gen_chk #(
  parameter int CODE_W     = 6,
  parameter int SAMP_W     = 8,
  parameter int SAMPLE_DIV = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tx_mode,
  input logic [CODE_W-1:0]        tone_code,
  input logic signed [SAMP_W-1:0] sample_o,
  input logic                     sample_vld_o,
  input logic                     drive_tone_o,
  input logic                     drive_bias_o
);
  import subtone_pkg::*;

  localparam int AMP = (1 << (SAMP_W - 1)) - 1;

  logic [1:0]  warm;
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst)            warm <= '0;
    else if (warm != 3) warm <= warm + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !drive_tone_o) begin
      seen <= 1'b0;
      gap  <= '0;
    end else if (sample_vld_o) begin
      seen <= 1'b1;
      gap  <= '0;
    end else if (gap != 16'hFFFF) begin
      gap  <= gap + 1'b1;
    end
  end

  p_drive_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(drive_tone_o && drive_bias_o));

  p_vld_needs_tone_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |-> drive_tone_o);

  p_vld_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_vld_o && seen) |-> (gap == 16'(SAMPLE_DIV - 1)));

  p_vld_single_r4: assert property (@(posedge clk) disable iff (rst)
    sample_vld_o |=> !sample_vld_o);

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !drive_tone_o |-> (sample_o == '0));

  p_amp_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_o <= SAMP_W'(AMP)) && (sample_o >= -SAMP_W'(AMP)));

  p_rx_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && !$past(tx_mode, 3)) |-> (!drive_tone_o && !drive_bias_o));

  p_notone_bias_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && $past(tx_mode, 3) && (32'($past(tone_code, 3)) >= 32'(NUM_TONES)))
      |-> (drive_bias_o && !drive_tone_o));
endmodule

bind subtone_gen subtone_gen_chk #(.CODE_W(CODE_W), .SAMP_W(SAMP_W), .SAMPLE_DIV(SAMPLE_DIV)) u_chk (
  .clk(clk), .rst(rst), .tx_mode(tx_mode), .tone_code(tone_code),
  .sample_o(sample_o), .sample_vld_o(sample_vld_o),
  .drive_tone_o(drive_tone_o), .drive_bias_o(drive_bias_o)
);

// File: tb/subtone_gen_tb_top.sv
module subtone_gen_tb_top;
  import subtone_pkg::*;

  localparam int SAMPLE_DIV = 4;
  localparam real CLK_HZ    = 1.0e6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tx_mode = 1'b0;
  logic [5:0]        tone_code = '0;
  logic              flip_req = 1'b0;
  logic signed [7:0] sample_o;
  logic              sample_vld_o;
  logic              drive_tone_o;
  logic              drive_bias_o;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  subtone_gen #(.SAMPLE_DIV(SAMPLE_DIV)) dut_i (
    .clk(clk), .rst(rst), .tx_mode(tx_mode), .tone_code(tone_code), .flip_req(flip_req),
    .sample_o(sample_o), .sample_vld_o(sample_vld_o),
    .drive_tone_o(drive_tone_o), .drive_bias_o(drive_bias_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_vld(output int s);
    int lim = 0;
    do begin
      @(negedge clk);
      lim++;
    end while (!sample_vld_o && lim < 1000);
    s = sample_o;
  endtask

  // R8: reset state
  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(sample_o == 0 && !sample_vld_o && !drive_tone_o && !drive_bias_o, "R8", "outputs in reset",
          {sample_o, 5'b0, sample_vld_o, drive_tone_o, drive_bias_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sample_o == 0 && !drive_tone_o && !drive_bias_o, "R8", "outputs after reset",
          {sample_o, 6'b0, drive_tone_o, drive_bias_o}, 0);
  endtask

  // R3: receive mode stays quiet, reverse request ignored
  task automatic t_rx_quiet();
    int bad = 0;
    tx_mode = 1'b0; tone_code = 6'd12;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0) flip_req = ~flip_req;
      @(negedge clk);
      if (drive_tone_o || drive_bias_o || sample_vld_o || sample_o != 0) bad++;
    end
    check(bad == 0, "R3", "receive-mode activity cycles", bad, 0);
    flip_req = 1'b0;
  endtask

  // R2 and R9: no-tone codes in transmit
  task automatic t_notone(input logic [5:0] code);
    int bad = 0;
    int both = 0;
    tx_mode = 1'b1; tone_code = code;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!drive_bias_o || drive_tone_o || sample_vld_o || sample_o != 0) bad++;
      if (drive_bias_o && drive_tone_o) both++;
    end
    check(bad == 0, "R2", $sformatf("no-tone code %0d wrong cycles", code), bad, 0);
    check(both == 0, "R9", "both indicators high", both, 0);
  endtask

  // R1, R4, R5: frequency, strobe spacing, amplitude
  task automatic t_freq(input int code);
    real exp_per, tol;
    int  prev = 0, s = 0, last_v = -1, bad_gap = 0, peak = 0, over = 0;
    int  t0 = -1, t1 = -1, lim;
    exp_per = CLK_HZ * 10.0 / real'(tone_dhz(code));
    tol     = exp_per * 0.003 + real'(SAMPLE_DIV);
    lim     = $rtoi(exp_per * 3.0) + 200;
    tx_mode = 1'b1; tone_code = 6'(code); flip_req = 1'b0;
    repeat (8) @(negedge clk);
    prev = sample_o;
    for (int i = 0; i < lim && t1 < 0; i++) begin
      @(negedge clk);
      if (!drive_tone_o) bad_gap++;
      if (sample_vld_o) begin
        s = sample_o;
        if (last_v >= 0 && cyc - last_v != SAMPLE_DIV) bad_gap++;
        last_v = cyc;
        if (s > peak) peak = s;
        if (-s > peak) peak = -s;
        if (s > 127 || s < -127) over++;
        if (prev < 0 && s >= 0) begin
          if (t0 < 0) t0 = cyc;
          else        t1 = cyc;
        end
        prev = s;
      end
    end
    check(t1 >= 0 && real'(t1 - t0) <= exp_per + tol && real'(t1 - t0) >= exp_per - tol,
          "R1", $sformatf("period cycles code %0d", code), t1 - t0, $rtoi(exp_per));
    check(bad_gap == 0, "R4", $sformatf("strobe spacing faults code %0d", code), bad_gap, 0);
    check(over == 0 && peak >= 126, "R5", $sformatf("peak magnitude code %0d", code), peak, 127);
  endtask

  // R7: phase restarts at zero
  task automatic t_start_phase();
    int s0, s1;
    tx_mode = 1'b0;
    repeat (10) @(negedge clk);
    tx_mode = 1'b1; tone_code = 6'd38; flip_req = 1'b0;
    wait_vld(s0);
    wait_vld(s1);
    check(s0 >= 0 && s0 <= 8, "R7", "first sample", s0, 2);
    check(s1 >= s0, "R7", "second sample not below first", s1, s0);
  endtask

  // R6: phase reversal negates, steady request keeps continuity
  task automatic t_reverse();
    int s0 = 0, s1;
    tx_mode = 1'b1; tone_code = 6'd38; flip_req = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3000 && s0 < 90; i++) wait_vld(s0);
    repeat (12) @(negedge clk);
    wait_vld(s1);
    check((s1 - s0) <= 6 && (s0 - s1) <= 6, "R6", "steady request continuity", s1, s0);
    s0 = s1;
    flip_req = 1'b1;
    repeat (12) @(negedge clk);
    wait_vld(s1);
    check((s1 + s0) <= 6 && (s1 + s0) >= -6, "R6", "first reversal negates", s1, -s0);
    s0 = s1;
    flip_req = 1'b0;
    repeat (12) @(negedge clk);
    wait_vld(s1);
    check((s1 + s0) <= 6 && (s1 + s0) >= -6, "R6", "second reversal negates", s1, -s0);
  endtask

  initial begin
    t_reset();
    t_rx_quiet();
    t_notone(6'd39);
    t_notone(6'd63);
    t_freq(0);
    t_freq(12);
    t_freq(20);
    t_freq(38);
    t_start_phase();
    t_reverse();
    tx_mode = 1'b0;
    t_rx_quiet();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule